// File: doc/BRIEF.md
# Daisy-Chained Bus Grant Arbiter

This block gives out ownership of a shared multi-master bus. Each device slot can raise a request in one of four priority classes, numbered 4 to 7, or on a separate non-processor (DMA) request. The requests of all slots are merged into five wired-OR request lines. A central picker issues a single grant on one of five grant lines. That grant then travels along the slots in slot order, starting at slot 0. The first slot that is requesting in that class takes the grant and blocks it from going further. That slot then raises the shared selection acknowledge and waits for the bus busy line to go low. When busy is low, the slot becomes the new bus owner.

Picking the next master overlaps the current transfer. A new grant can be issued and accepted while another slot still holds busy. The waiting slot keeps the acknowledge raised until it takes the bus. While the acknowledge is raised, the picker issues no other grant. A grant that reaches the end of the chain without a taker is withdrawn.

The slot count is a parameter and may be up to 20. A device ends its ownership by pulsing its done input. A slot that is not requesting stands for an empty position, and it passes every grant through unchanged.

Top module: `bus_grant_chain`

## Requirements
- R1: During reset and on the first cycle after it, grant_o, bus_req_o, sack_o, busy_o, slot_sel_o and slot_owner_o are all zero.
- R2: bus_req_o bit k (k = 0..3) is the OR of every slot's request for class 4+k. Bit 4 is the OR of the non-processor requests. A slot's own requests are left out while it is selected or owns the bus.
- R3: When no grant is out and sack_o is low, the clock edge after the request is seen drives grant_o one-hot. The non-processor class wins over all others. Among the numbered classes, 7 beats 6, 6 beats 5 and 5 beats 4. The same bit layout as bus_req_o is used.
- R4: A grant passes through every slot that is not requesting its class. The lowest-numbered slot that is requesting it captures the grant on the next edge: its slot_sel_o bit and sack_o go high, and no slot further down sees the grant.
- R5: The edge after sack_o rises clears grant_o.
- R6: While sack_o is high, no new grant is issued.
- R7: A selected slot becomes owner on the first edge at which busy_o is low. Its slot_sel_o bit (and so sack_o) falls on that same edge. Owners take the bus in the order in which they were selected.
- R8: A grant can be issued and captured while busy_o is held by another owner.
- R9: An owner gives up the bus on the edge at which its slot_done_i bit is high. busy_o falls on that edge.
- R10: If a grant reaches the end of the chain with no slot taking it, it is withdrawn on the next edge and sack_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_lvl_req_i | input | 4*NSLOTS | Bit 4*s+k: slot s requests class 4+k |
| slot_npr_req_i | input | NSLOTS | Non-processor request per slot |
| slot_done_i | input | NSLOTS | Owner ends its tenure |
| bus_req_o | output | 5 | Merged request lines, bit 4 = non-processor |
| grant_o | output | 5 | One-hot grant issued into slot 0 |
| sack_o | output | 1 | Selection acknowledge (any slot selected) |
| busy_o | output | 1 | Bus busy (any slot owns the bus) |
| slot_sel_o | output | NSLOTS | Slot holds a captured grant |
| slot_owner_o | output | NSLOTS | Slot owns the bus |

## Verification
The bench drives inputs on the falling edge and reads the outputs on the next falling edge. Merged requests are visible at once, with no clock edge between. The grant is visible after one edge, the selection after two edges and ownership after three edges when the bus is idle. Each release adds one edge before the next owner takes over. An unclaimed grant drops one edge after it appears. Every timed check is placed at the falling edge that follows the exact number of rising edges for its result. A scoreboard queue filled by the stimulus tasks holds the expected order of owners, and a monitor checks each new owner against that queue as ownership appears.

// File: rtl/bus_grant_chain.sv
module bus_grant_chain #(
  parameter int NSLOTS = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [4*NSLOTS-1:0]   slot_lvl_req_i,
  input  logic [NSLOTS-1:0]     slot_npr_req_i,
  input  logic [NSLOTS-1:0]     slot_done_i,
  output logic [4:0]            bus_req_o,
  output logic [4:0]            grant_o,
  output logic                  sack_o,
  output logic                  busy_o,
  output logic [NSLOTS-1:0]     slot_sel_o,
  output logic [NSLOTS-1:0]     slot_owner_o
);
  localparam int NCLS = 5;

  logic [NCLS-1:0]   chain [NSLOTS+1];
  logic [NCLS-1:0]   want  [NSLOTS];
  logic [NSLOTS-1:0] sel_q, own_q, take;
  logic [NCLS-1:0]   gnt_q, pick, req_or;

  assign chain[0] = gnt_q;

  generate
    for (genvar s = 0; s < NSLOTS; s++) begin : g_slot
      assign want[s]     = {slot_npr_req_i[s], slot_lvl_req_i[4*s +: 4]} & {NCLS{~(sel_q[s] | own_q[s])}};
      assign take[s]     = |(chain[s] & want[s]);
      assign chain[s+1]  = (sel_q[s] | take[s]) ? '0 : chain[s];

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          sel_q[s] <= 1'b0;
          own_q[s] <= 1'b0;
        end else begin
          if (take[s])                     sel_q[s] <= 1'b1;
          else if (sel_q[s] && !busy_o)    sel_q[s] <= 1'b0;
          if (sel_q[s] && !busy_o)         own_q[s] <= 1'b1;
          else if (own_q[s] && slot_done_i[s]) own_q[s] <= 1'b0;
        end
      end
    end
  endgenerate

  always_comb begin
    req_or = '0;
    for (int s = 0; s < NSLOTS; s++) req_or = req_or | want[s];
  end

  always_comb begin
    pick = '0;
    if      (req_or[4]) pick[4] = 1'b1;
    else if (req_or[3]) pick[3] = 1'b1;
    else if (req_or[2]) pick[2] = 1'b1;
    else if (req_or[1]) pick[1] = 1'b1;
    else if (req_or[0]) pick[0] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              gnt_q <= '0;
    else if (gnt_q != '0) begin
      if (sack_o || chain[NSLOTS] != '0) gnt_q <= '0;
    end else if (!sack_o)    gnt_q <= pick;
  end

  assign bus_req_o    = req_or;
  assign grant_o      = gnt_q;
  assign sack_o       = |sel_q;
  assign busy_o       = |own_q;
  assign slot_sel_o   = sel_q;
  assign slot_owner_o = own_q;
endmodule

// File: rtl/bus_grant_chain_chk.sv
module bus_grant_chain_chk #(
  parameter int NSLOTS = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [4:0]        bus_req_o,
  input logic [4:0]        grant_o,
  input logic              sack_o,
  input logic              busy_o,
  input logic [NSLOTS-1:0] slot_sel_o,
  input logic [NSLOTS-1:0] slot_owner_o
);
  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o)); // R3

  AST_GNT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(grant_o) == 5'b0 && grant_o != 5'b0) |-> (($past(bus_req_o) & grant_o) != 5'b0)); // R3

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_sel_o)); // R4

  AST_GNT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sack_o) |=> (grant_o == 5'b0)); // R5

  AST_NO_NEW_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    (sack_o && grant_o == 5'b0) |=> (grant_o == 5'b0)); // R6

  AST_OWNER_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_owner_o)); // R7

  AST_WAIT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> (slot_owner_o == '0 || slot_owner_o == $past(slot_owner_o))); // R7
endmodule

bind bus_grant_chain bus_grant_chain_chk #(.NSLOTS(NSLOTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req_o(bus_req_o), .grant_o(grant_o),
  .sack_o(sack_o), .busy_o(busy_o), .slot_sel_o(slot_sel_o),
  .slot_owner_o(slot_owner_o)
);

// File: tb/test_bus_grant_chain.sv
module test_bus_grant_chain;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [4*N-1:0] lvl = '0;
  logic [N-1:0]   npr = '0;
  logic [N-1:0]   done = '0;
  logic [4:0]     bus_req, grant;
  logic           sack, busy;
  logic [N-1:0]   sel, owner;

  int nchk = 0;
  int nfail = 0;
  int expq[$];
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_grant_chain #(.NSLOTS(N)) i_bus_grant_chain (
    .clk(clk), .rst_n(rst_n), .slot_lvl_req_i(lvl), .slot_npr_req_i(npr),
    .slot_done_i(done), .bus_req_o(bus_req), .grant_o(grant), .sack_o(sack),
    .busy_o(busy), .slot_sel_o(sel), .slot_owner_o(owner)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_owner(int s);
    expq.push_back(s);
  endtask

  task automatic release_slot(int s);
    done[s] = 1'b1;
    tick();
    done[s] = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  endtask

  logic [N-1:0] prev_owner = '0;
  always @(negedge clk) begin : monitor
    int idx;
    int want;
    if (rst_n && owner != prev_owner && owner != '0) begin
      idx = -1;
      for (int i = 0; i < N; i++) if (owner[i]) idx = i;
      nchk++;
      if (expq.size() == 0) begin
        nfail++;
        $display("FAIL R7 owner order actual=%0d expected=none", idx);
      end else begin
        want = expq.pop_front();
        if (idx != want) begin
          nfail++;
          $display("FAIL R7 owner order actual=%0d expected=%0d", idx, want);
        end
      end
    end
    prev_owner = owner;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    nchk++;
    nfail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) tick();
    chk("R1 grant in reset", grant, 0);
    chk("R1 owner in reset", owner, 0);
    rst_n = 1'b1;
    tick();
    chk("R1 grant after reset", grant, 0);
    chk("R1 sack/busy after reset", {sack, busy}, 0);
    chk("R1 sel after reset", sel, 0);
    chk("R1 bus_req after reset", bus_req, 0);

    // single request, idle bus: slot 3, class 5
    lvl[4*3+1] = 1'b1;
    expect_owner(3);
    #1 chk("R2 merged request", bus_req, 5'b00010);
    tick();
    chk("R3 grant class 5", grant, 5'b00010);
    tick();
    chk("R4 sack raised", sack, 1);
    chk("R4 slot 3 selected", sel, 8'h08);
    chk("R2 own request masked", bus_req, 0);
    lvl[4*3+1] = 1'b0;
    tick();
    chk("R5 grant dropped", grant, 0);
    chk("R7 slot 3 owns", owner, 8'h08);
    chk("R7 sack dropped", sack, 0);
    chk("R7 busy", busy, 1);
    release_slot(3);
    chk("R9 busy released", busy, 0);
    chk("R9 owner cleared", owner, 0);
    tick();

    // priority and overlap: slot1 class4, slot5 class7, slot6 non-processor
    lvl[4*1+0] = 1'b1;
    lvl[4*5+3] = 1'b1;
    npr[6] = 1'b1;
    expect_owner(6);
    expect_owner(5);
    expect_owner(1);
    tick();
    chk("R3 non-processor wins", grant, 5'b10000);
    tick();
    chk("R4 slot 6 selected", sel, 8'h40);
    npr[6] = 1'b0;
    tick();
    chk("R7 slot 6 owns", owner, 8'h40);
    tick();
    chk("R8 grant while busy", {busy, grant}, 6'b101000);
    tick();
    chk("R8 slot 5 selected while busy", sel, 8'h20);
    lvl[4*5+3] = 1'b0;
    tick();
    tick();
    chk("R6 no grant while sack", grant, 0);
    chk("R7 waits for busy", {sack, owner}, {1'b1, 8'h40});
    chk("R2 class 4 still requested", bus_req, 5'b00001);
    release_slot(6);
    chk("R9 slot 6 released", owner, 0);
    tick();
    chk("R7 slot 5 takes bus", owner, 8'h20);
    tick();
    chk("R3 class 4 granted", grant, 5'b00001);
    tick();
    chk("R4 slot 1 selected", sel, 8'h02);
    lvl[4*1+0] = 1'b0;
    release_slot(5);
    tick();
    chk("R7 slot 1 takes bus", owner, 8'h02);
    release_slot(1);
    tick();

    // daisy chain: slots 2 and 4 both class 6
    lvl[4*2+2] = 1'b1;
    lvl[4*4+2] = 1'b1;
    expect_owner(2);
    expect_owner(4);
    tick();
    chk("R3 class 6 granted", grant, 5'b00100);
    tick();
    chk("R4 nearer slot 2 captures", sel, 8'h04);
    chk("R2 wired-OR keeps slot 4", bus_req, 5'b00100);
    lvl[4*2+2] = 1'b0;
    tick();
    tick();
    chk("R4 second grant class 6", grant, 5'b00100);
    tick();
    chk("R4 passes slot 3 to slot 4", sel, 8'h10);
    lvl[4*4+2] = 1'b0;
    release_slot(2);
    tick();
    chk("R7 slot 4 takes bus", owner, 8'h10);
    release_slot(4);
    tick();

    // unclaimed grant
    lvl[4*7+0] = 1'b1;
    tick();
    chk("R10 grant issued", grant, 5'b00001);
    lvl[4*7+0] = 1'b0;
    tick();
    chk("R10 unclaimed grant withdrawn", grant, 0);
    chk("R10 no sack", sack, 0);
    tick();
    chk("R10 stays idle", {sack, busy, grant}, 0);

    repeat (3) tick();
    chk("R7 all expected owners seen", expq.size(), 0);
    finish_run();
  end
endmodule